// File: doc/BRIEF.md
# Bank-Owned Dual-Port Memory

A shared word memory cut into equal banks and reached from two independent ports, called left and right. Each port has its own chip enable, write enable, address and write data, plus its own read data and error output. An external bank-select vector gives every bank to exactly one port. A set bit gives the bank to the left port and a clear bit gives it to the right port. Because a bank always has one owner, the two ports never collide, and they can work in different banks in the same clock cycle with no arbitration.

The upper address bits of a port name a bank, and the lower bits name a word inside it. If a port touches a bank it owns, it gets a normal synchronous read or write. If it touches a bank owned by the other port, nothing in the memory changes. The read returns zero, and the port's error line pulses for one cycle. The bank depth and the bank count are parameters, so a shallow memory can stand in during simulation.

Top module: `bank_dpram`

## Requirements
- R1: While reset is held, and until the first access after it, both read-data outputs are zero and both error outputs are low.
- R2: The address is {bank, word}: the upper clog2(NUM_BANKS) bits select the bank, the lower clog2(BANK_DEPTH) bits select the word, and bank i is governed by bank_sel bit i.
- R3: bank_sel bit i = 1 gives bank i to the left port; bit i = 0 gives it to the right port; the ownership in force is the value of bank_sel in the access cycle.
- R4: A write (ce=1, we=1) to an owned bank stores the data at that word; a read (ce=1, we=0) of an owned bank shows the stored word on that port's rdata in the next cycle.
- R5: A write to a bank the port does not own leaves the memory unchanged.
- R6: A read of a bank the port does not own gives rdata equal to zero in the next cycle.
- R7: Any access (ce=1) to a bank the port does not own drives that port's err high for exactly the next cycle; an owned access or an idle cycle leaves err low in the next cycle.
- R8: The two ports can each access a different bank in the same cycle, and neither access affects the other.
- R9: In the cycle after a cycle with no read on a port (idle or write), that port's rdata is zero.
- R10: One port may own every bank, or none, and the other port then sees R5 to R7 on every access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel | input | NUM_BANKS | Per-bank owner: 1 = left, 0 = right |
| l_ce | input | 1 | Left access enable |
| l_we | input | 1 | Left write (1) or read (0) |
| l_addr | input | ADDR_W | Left {bank, word} address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, one cycle after the read |
| l_err | output | 1 | Left access to an unowned bank, one-cycle pulse |
| r_ce | input | 1 | Right access enable |
| r_we | input | 1 | Right write (1) or read (0) |
| r_addr | input | ADDR_W | Right {bank, word} address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, one cycle after the read |
| r_err | output | 1 | Right access to an unowned bank, one-cycle pulse |

## Verification
The bench builds the block with four banks of sixteen 16-bit words, which gives a 6-bit address. At that size it can fill every word, and it can make thousands of random accesses that land on each bank and word many times while bank_sel changes every cycle. This covers ownership changes between back-to-back accesses, both ports writing into and reading from the same bank in one cycle, and the all-left and all-right ownership corners.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  // Owner encoding of one bank-select bit.
  typedef enum logic {
    OWN_RIGHT = 1'b0,
    OWN_LEFT  = 1'b1
  } bdp_owner_e;
endpackage

// File: rtl/bdp_rst_sync.sv
module bdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bdp_port_dec.sv
module bdp_port_dec #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int WORD_W    = 8,
  parameter bit IS_LEFT   = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic                     we,
  input  logic [BANK_W+WORD_W-1:0] addr,
  input  logic [NUM_BANKS-1:0]     bank_sel,
  output logic [WORD_W-1:0]        word,
  output logic [NUM_BANKS-1:0]     hit,
  output logic                     err,
  output logic                     rd_ok,
  output logic [BANK_W-1:0]        rd_idx
);
  logic [BANK_W-1:0] bank_idx;
  logic              owned;
  logic              err_d, rd_ok_d;
  logic [BANK_W-1:0] rd_idx_d;

  assign bank_idx = addr[BANK_W+WORD_W-1:WORD_W];
  assign word     = addr[WORD_W-1:0];
  assign owned    = (bank_sel[bank_idx] == IS_LEFT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign hit[b] = ce && owned && (bank_idx == BANK_W'(b));
  end

  always_comb begin
    err_d    = ce && !owned;
    rd_ok_d  = ce && !we && owned;
    rd_idx_d = rd_ok_d ? bank_idx : rd_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err    <= 1'b0;
      rd_ok  <= 1'b0;
      rd_idx <= '0;
    end else begin
      err    <= err_d;
      rd_ok  <= rd_ok_d;
      rd_idx <= rd_idx_d;
    end
  end
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank
  import bdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  bdp_owner_e        owner,
  input  logic              l_act,
  input  logic              l_we,
  input  logic [WORD_W-1:0] l_word,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              r_act,
  input  logic              r_we,
  input  logic [WORD_W-1:0] r_word,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              act, we;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] wdata;

  // Only the owning port's request reaches the array.
  always_comb begin
    if (owner == OWN_LEFT) begin
      act = l_act; we = l_we; word = l_word; wdata = l_wdata;
    end else begin
      act = r_act; we = r_we; word = r_word; wdata = r_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (act && we)  mem[word] <= wdata;
    if (act && !we) q <= mem[word];
  end
endmodule

// File: rtl/bank_dpram.sv
module bank_dpram
  import bdp_pkg::*;
#(
  parameter  int DATA_W     = 16,
  parameter  int NUM_BANKS  = 4,
  parameter  int BANK_DEPTH = 256,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int WORD_W     = $clog2(BANK_DEPTH),
  localparam int ADDR_W     = BANK_W + WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_sel,
  input  logic                 l_ce,
  input  logic                 l_we,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [DATA_W-1:0]    l_wdata,
  output logic [DATA_W-1:0]    l_rdata,
  output logic                 l_err,
  input  logic                 r_ce,
  input  logic                 r_we,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic [DATA_W-1:0]    r_wdata,
  output logic [DATA_W-1:0]    r_rdata,
  output logic                 r_err
);
  logic                 rst_sync_n;
  logic [WORD_W-1:0]    l_word, r_word;
  logic [NUM_BANKS-1:0] l_hit, r_hit;
  logic                 l_rd_ok, r_rd_ok;
  logic [BANK_W-1:0]    l_rd_idx, r_rd_idx;
  logic [DATA_W-1:0]    bank_q [NUM_BANKS];

  bdp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  bdp_port_dec #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .WORD_W(WORD_W), .IS_LEFT(1'b1)) u_dec_l (
    .clk(clk), .rst_n(rst_sync_n), .ce(l_ce), .we(l_we), .addr(l_addr), .bank_sel(bank_sel),
    .word(l_word), .hit(l_hit), .err(l_err), .rd_ok(l_rd_ok), .rd_idx(l_rd_idx));

  bdp_port_dec #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .WORD_W(WORD_W), .IS_LEFT(1'b0)) u_dec_r (
    .clk(clk), .rst_n(rst_sync_n), .ce(r_ce), .we(r_we), .addr(r_addr), .bank_sel(bank_sel),
    .word(r_word), .hit(r_hit), .err(r_err), .rd_ok(r_rd_ok), .rd_idx(r_rd_idx));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bdp_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .owner(bdp_owner_e'(bank_sel[i])),
      .l_act(l_hit[i]), .l_we(l_we), .l_word(l_word), .l_wdata(l_wdata),
      .r_act(r_hit[i]), .r_we(r_we), .r_word(r_word), .r_wdata(r_wdata),
      .q(bank_q[i]));
  end

  // Read data is forced to zero unless the previous cycle was an owned read.
  assign l_rdata = l_rd_ok ? bank_q[l_rd_idx] : '0;
  assign r_rdata = r_rd_ok ? bank_q[r_rd_idx] : '0;
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int WORD_W    = 8
) (
  input logic                     clk,
  input logic                     rst_ni,
  input logic [NUM_BANKS-1:0]     bank_sel,
  input logic                     l_ce,
  input logic                     l_we,
  input logic [BANK_W+WORD_W-1:0] l_addr,
  input logic [DATA_W-1:0]        l_rdata,
  input logic                     l_err,
  input logic                     r_ce,
  input logic                     r_we,
  input logic [BANK_W+WORD_W-1:0] r_addr,
  input logic [DATA_W-1:0]        r_rdata,
  input logic                     r_err
);
  localparam int AW = BANK_W + WORD_W;

  // R7
  l_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (l_ce && !bank_sel[l_addr[AW-1 -: BANK_W]]) |=> l_err);
  // R7
  l_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(l_ce && !bank_sel[l_addr[AW-1 -: BANK_W]]) |=> !l_err);
  // R7
  r_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (r_ce && bank_sel[r_addr[AW-1 -: BANK_W]]) |=> r_err);
  // R7
  r_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(r_ce && bank_sel[r_addr[AW-1 -: BANK_W]]) |=> !r_err);
  // R6
  l_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    l_err |-> (l_rdata == '0));
  // R6
  r_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    r_err |-> (r_rdata == '0));
  // R9
  l_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(l_ce && !l_we) |=> (l_rdata == '0));
  // R9
  r_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(r_ce && !r_we) |=> (r_rdata == '0));
endmodule

bind bank_dpram bdp_chk #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_ni(rst_sync_n), .bank_sel(bank_sel),
  .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_rdata(l_rdata), .l_err(l_err),
  .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_rdata(r_rdata), .r_err(r_err));

// File: tb/test_bank_dpram.sv
`timescale 1ns/1ps
module test_bank_dpram;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int BD = 16;
  localparam int AW = 6;
  localparam int WW = 4;

  logic          clk;
  logic          rst_n;
  logic [NB-1:0] bank_sel;
  logic          l_ce, l_we, r_ce, r_we;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic          l_err, r_err;

  int checks = 0;
  int fails  = 0;
  int model_mem [NB*BD];
  logic [DW-1:0] exp_lr, exp_rr;
  logic          exp_le, exp_re;
  string         tag_lr, tag_rr;

  bank_dpram #(.DATA_W(DW), .NUM_BANKS(NB), .BANK_DEPTH(BD)) i_bank_dpram (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_err(l_err),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_err(r_err));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic compare_outputs();
    check(tag_lr, "l_rdata", l_rdata, exp_lr);
    check(tag_rr, "r_rdata", r_rdata, exp_rr);
    check("R7", "l_err", DW'(l_err), DW'(exp_le));
    check("R7", "r_err", DW'(r_err), DW'(exp_re));
  endtask

  // One clock of stimulus: check the previous cycle's result, then drive new inputs
  // and compute what the model expects one cycle later.
  task automatic step(input logic [NB-1:0] sel,
                      input logic lce, input logic lwe, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                      input logic rce, input logic rwe, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    bit l_own, r_own;
    @(negedge clk);
    compare_outputs();
    bank_sel = sel;
    l_ce = lce; l_we = lwe; l_addr = la; l_wdata = ld;
    r_ce = rce; r_we = rwe; r_addr = ra; r_wdata = rd;
    l_own = sel[la[AW-1:WW]];          // R3: bit set -> left owns
    r_own = !sel[ra[AW-1:WW]];
    exp_le = lce && !l_own;
    exp_re = rce && !r_own;
    exp_lr = '0; tag_lr = "R9";
    exp_rr = '0; tag_rr = "R9";
    if (lce && !lwe) begin
      if (l_own) begin exp_lr = DW'(model_mem[la]); tag_lr = "R4"; end
      else tag_lr = "R6";
    end
    if (rce && !rwe) begin
      if (r_own) begin exp_rr = DW'(model_mem[ra]); tag_rr = "R4"; end
      else tag_rr = "R6";
    end
    // R5: only owned writes update the model.
    if (lce && lwe && l_own) model_mem[la] = int'(ld);
    if (rce && rwe && r_own) model_mem[ra] = int'(rd);
  endtask

  task automatic idle();
    step(bank_sel, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bank_sel = '0;
    l_ce = 0; l_we = 0; l_addr = '0; l_wdata = '0;
    r_ce = 0; r_we = 0; r_addr = '0; r_wdata = '0;
    exp_lr = '0; exp_rr = '0; exp_le = 0; exp_re = 0;
    tag_lr = "R1"; tag_rr = "R1";
    for (int i = 0; i < NB*BD; i++) model_mem[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet under reset
    compare_outputs();
    rst_n = 1'b1;
    repeat (4) idle();

    // R10: left owns every bank and fills it; right's writes to the same words are refused (R5, R7).
    for (int i = 0; i < NB*BD; i++)
      step(4'hF, 1'b1, 1'b1, AW'(i), DW'(16'hA500 ^ (i * 16'h0103)),
                 1'b1, 1'b1, AW'(NB*BD-1-i), DW'(16'hDEAD));
    // R4: read the fill back through the left port.
    for (int i = 0; i < NB*BD; i++)
      step(4'hF, 1'b1, 1'b0, AW'(i), '0, 1'b1, 1'b0, AW'(i), '0);

    // R2/R3: left writes bank 1 word 3; ownership moves to right, which reads the same word.
    step(4'b0010, 1'b1, 1'b1, 6'h13, 16'h1357, 1'b0, 1'b0, '0, '0);
    step(4'b0000, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 6'h13, '0);
    idle();
    check("R2", "model word 0x13", DW'(model_mem[6'h13]), 16'h1357);

    // R8: both ports write then read different banks in the same cycles.
    step(4'b0011, 1'b1, 1'b1, 6'h05, 16'h0BAD, 1'b1, 1'b1, 6'h35, 16'hF00D);
    step(4'b0011, 1'b1, 1'b0, 6'h05, '0, 1'b1, 1'b0, 6'h35, '0);
    idle();

    // R10: right owns everything; left accesses all fail and change nothing.
    for (int i = 0; i < NB; i++)
      step(4'h0, 1'b1, i[0], AW'(i*BD + 2), 16'h7777, 1'b1, 1'b0, AW'(i*BD + 2), '0);
    idle();

    // Random traffic with ownership changing every cycle (R3..R9).
    for (int n = 0; n < 3000; n++)
      step(NB'($urandom), 1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom),
                          1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom));
    idle();
    @(negedge clk);
    compare_outputs();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule